// File: doc/BRIEF.md
# Inhibitable Single-Bit RAM Element with Two Access Latencies

This block is a clock-cycle model of a 256-word by 1-bit static memory element. An 8-bit address picks one cell. A write-select input chooses between writing that cell and reading it. An inhibit input acts as the chip select, and the data output can go to high impedance. The model holds the storage array, two latency timers and the output-enable logic. Analog levels, power modes and drive strength are not modelled.

The address decoder keeps running while inhibit is high. Any new address takes a long, fixed decode delay before it can be read. If the address has already settled while inhibit was high, releasing inhibit makes the data appear after a much shorter delay. Because of this, a larger memory can be built from many elements that share one address bus. All elements decode in parallel, and stepping the inhibit lines then reads one element after another on a shared wired-OR line.

The read side works as a stream source. `rd_valid` marks the cycles in which `dout` carries the addressed cell. There is no ready input and no back-pressure: a consumer must take the bit during a valid cycle. The bit stays readable for as long as the address and inhibit are held.

Top module: `inhram_top`

## Requirements
- R1: A write happens on a rising edge where `wr_sel` is 1 and `inhibit` is 0. It stores `din` into the cell selected by `addr`. If the address is held, the new value is visible on `dout` in the cycle after that edge.
- R2: A read does not disturb the array. With the address held, `dout` keeps the same value over repeated valid cycles, and other cells keep their contents.
- R3: While `inhibit` is 1, `wr_sel` and `din` have no effect. The addressed cell reads back unchanged after inhibit is released.
- R4: While `inhibit` is 1, `dout_en` is 0 (so `dout` is high impedance) and `rd_valid` is 0.
- R5: After `addr` changes, `rd_valid` stays 0 until the new address has been sampled by ADDR_LAT rising edges (default 5). The edge that first sees the new address counts as the first of these.
- R6: Once inhibit goes low, `rd_valid` needs INH_LAT rising edges (default 1) with inhibit low before it can be 1.
- R7: The decode delay keeps counting while inhibited. If the address was held for at least ADDR_LAT edges under inhibit, `rd_valid` rises after only INH_LAT edges of release.
- R8: With HOLD_OLD set (the default), whenever `dout_en` is 1 and `rd_valid` is 0, `dout` holds the last value it showed while valid. If HOLD_OLD is clear, it is unknown instead.
- R9: During and just after reset, `rd_valid` is 0 and the held output value is 0. Out of reset, address 0 counts as the current address for the decode delay.
- R10: If `addr` differs from the address sampled at the last edge, `rd_valid` drops to 0 in that same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of timers and output holding register |
| addr | input | ADDR_W | Cell address, read and write |
| wr_sel | input | 1 | 1 = write `din` on the edge, 0 = read |
| din | input | 1 | Write data bit |
| inhibit | input | 1 | 1 = element deselected: writes blocked, output released |
| dout | output | 1 | Tri-state data output, high impedance when `dout_en` is 0 |
| dout_en | output | 1 | Output driver enable (the inverse of inhibit) |
| rd_valid | output | 1 | `dout` carries the addressed cell this cycle |

## Verification
Some properties are checked on every cycle. High impedance and no valid under inhibit is one. `rd_valid` may never rise before a checker-side count of stable-address edges and released-inhibit edges reaches ADDR_LAT and INH_LAT, and it must rise once both are reached. An address change drops valid at once, and the held output value does not move while invalid. Cell contents can only be seen through the bench's scenarios. These cover write-then-read against a reference array, writes attempted under inhibit, non-destructive repeated reads, and the contrast between the slow address path and the fast release path.

// File: rtl/inhram_pkg.sv
package inhram_pkg;

  // Driver state of the data pin
  typedef enum logic [1:0] {
    PIN_OFF  = 2'd0,  // released, high impedance
    PIN_PEND = 2'd1,  // driven, decode not finished
    PIN_DATA = 2'd2   // driven with the addressed cell
  } pin_mode_e;

  // Bits needed to count from 0 up to lim inclusive
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/inhram_lat_timer.sv
// Saturating age counter: done once LAT edges have elapsed.
module inhram_lat_timer #(
  parameter int unsigned LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero,     // force age to 0
  input  logic restart,  // this edge is the first counted edge
  output logic done
);
  localparam int unsigned CW = inhram_pkg::cnt_width(LAT);
  localparam logic [CW-1:0] LIM = CW'(LAT);

  logic [CW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)          age <= '0;
    else if (zero)       age <= '0;
    else if (restart)    age <= CW'(1);
    else if (age != LIM) age <= age + 1'b1;
  end

  assign done = (age >= LIM);
endmodule

// File: rtl/inhram_cells.sv
// Storage array: one flop per word with its own decoded write strobe.
module inhram_cells #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rbit
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] word;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic strobe;
    assign strobe = we && (waddr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (strobe) word[i] <= wbit;
    end
  end

  assign rbit = word[raddr];
endmodule

// File: rtl/inhram_out_stage.sv
// Output driver: release, pending value, or cell data.
module inhram_out_stage #(
  parameter bit HOLD_OLD = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit,
  input  logic ready,      // address settled and inhibit timer done
  input  logic cell_bit,
  output logic drive_en,
  output logic data_bit,
  output logic valid
);
  import inhram_pkg::*;

  pin_mode_e mode;
  logic      last_q;
  logic      pend_bit;

  always_comb begin
    if (inhibit)    mode = PIN_OFF;
    else if (ready) mode = PIN_DATA;
    else            mode = PIN_PEND;
  end

  assign drive_en = (mode != PIN_OFF);
  assign valid    = (mode == PIN_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= 1'b0;
    else if (valid) last_q <= cell_bit;
  end

  if (HOLD_OLD) begin : g_hold
    assign pend_bit = last_q;
  end else begin : g_unknown
    assign pend_bit = 1'bx;
  end

  assign data_bit = valid ? cell_bit : pend_bit;
endmodule

// File: rtl/inhram_top.sv
module inhram_top #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ADDR_LAT = 5,
  parameter int unsigned INH_LAT  = 1,
  parameter bit          HOLD_OLD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_sel,
  input  logic              din,
  input  logic              inhibit,
  output logic              dout,
  output logic              dout_en,
  output logic              rd_valid
);
  logic [ADDR_W-1:0] addr_q;
  logic addr_match, addr_done, inh_done;
  logic write_go, cell_bit, dout_data, rd_ready;

  // Decoder input register: keeps tracking addr whatever inhibit does
  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr;
  end

  assign addr_match = (addr == addr_q);

  inhram_lat_timer #(.LAT(ADDR_LAT)) u_addr_tmr (
    .clk(clk), .rst_n(rst_n), .zero(1'b0), .restart(!addr_match), .done(addr_done)
  );

  inhram_lat_timer #(.LAT(INH_LAT)) u_inh_tmr (
    .clk(clk), .rst_n(rst_n), .zero(inhibit), .restart(1'b0), .done(inh_done)
  );

  assign write_go = wr_sel && !inhibit;

  inhram_cells #(.ADDR_W(ADDR_W)) u_cells (
    .clk(clk), .we(write_go), .waddr(addr), .wbit(din),
    .raddr(addr_q), .rbit(cell_bit)
  );

  assign rd_ready = addr_match && addr_done && inh_done;

  inhram_out_stage #(.HOLD_OLD(HOLD_OLD)) u_out (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .ready(rd_ready),
    .cell_bit(cell_bit), .drive_en(dout_en), .data_bit(dout_data), .valid(rd_valid)
  );

  assign dout = dout_en ? dout_data : 1'bz;
endmodule

// File: rtl/inhram_checker.sv
module inhram_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ADDR_LAT = 5,
  parameter int unsigned INH_LAT  = 1,
  parameter bit          HOLD_OLD = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              inhibit,
  input logic              dout_en,
  input logic              rd_valid,
  input logic              dout_val
);
  localparam int unsigned AW = inhram_pkg::cnt_width(ADDR_LAT);
  localparam int unsigned IW = inhram_pkg::cnt_width(INH_LAT);

  logic [ADDR_W-1:0] seen_addr;
  logic [AW-1:0]     a_cnt;
  logic [IW-1:0]     i_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_addr <= '0;
      a_cnt     <= '0;
      i_cnt     <= '0;
    end else begin
      seen_addr <= addr;
      if (addr != seen_addr)          a_cnt <= AW'(1);
      else if (a_cnt < AW'(ADDR_LAT)) a_cnt <= a_cnt + 1'b1;
      if (inhibit)                    i_cnt <= '0;
      else if (i_cnt < IW'(INH_LAT))  i_cnt <= i_cnt + 1'b1;
    end
  end

  a_r4_hiz_under_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!dout_en && !rd_valid));

  a_r5_addr_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (a_cnt >= AW'(ADDR_LAT)));

  a_r6_release_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (i_cnt >= IW'(INH_LAT)));

  a_r7_valid_when_settled: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit && addr == seen_addr && a_cnt >= AW'(ADDR_LAT) && i_cnt >= IW'(INH_LAT))
      |-> rd_valid);

  a_r10_change_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != seen_addr) |-> !rd_valid);

  if (HOLD_OLD) begin : g_hold_chk
    a_r8_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_en && !rd_valid) |-> $stable(dout_val));
  end
endmodule

bind inhram_top inhram_checker #(
  .ADDR_W(ADDR_W), .ADDR_LAT(ADDR_LAT), .INH_LAT(INH_LAT), .HOLD_OLD(HOLD_OLD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .inhibit(inhibit),
  .dout_en(dout_en), .rd_valid(rd_valid), .dout_val(dout_data)
);

// File: tb/inhram_top_tb.sv
`timescale 1ns/1ps
module inhram_top_tb;
  localparam int ADDR_LAT = 5;
  localparam int INH_LAT  = 1;

  typedef struct packed {
    logic       wr;
    logic [7:0] a;
    logic       d;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 1'b1}, '{1'b1, 8'hFF, 1'b1}, '{1'b1, 8'hA5, 1'b1},
    '{1'b1, 8'h5A, 1'b0}, '{1'b0, 8'h00, 1'b0}, '{1'b0, 8'hFF, 1'b0},
    '{1'b0, 8'hA5, 1'b0}, '{1'b1, 8'hA5, 1'b0}, '{1'b0, 8'hA5, 1'b0},
    '{1'b0, 8'h5A, 1'b0}, '{1'b1, 8'h3C, 1'b1}, '{1'b0, 8'h3C, 1'b0},
    '{1'b0, 8'h00, 1'b0}, '{1'b1, 8'h01, 1'b1}, '{1'b0, 8'h01, 1'b0},
    '{1'b0, 8'h00, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic wr_sel = 1'b0, din = 1'b0, inhibit = 1'b0;
  wire  dout;
  logic dout_en, rd_valid;

  logic [255:0] ref_mem = '0;
  logic [7:0]   cur_a = 8'h00;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  inhram_top u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_sel(wr_sel), .din(din),
    .inhibit(inhibit), .dout(dout), .dout_en(dout_en), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_data(input string req, input logic expv);
    check(rd_valid === 1'b1 && dout_en === 1'b1, {req, " valid"}, int'(rd_valid), 1);
    check(dout === expv, {req, " data"}, int'(dout), int'(expv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    edges(3);
    check(rd_valid === 1'b0, "R9 valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    #1;
    check(rd_valid === 1'b0, "R9 valid after reset", int'(rd_valid), 0);
    check(dout_en === 1'b1 && dout === 1'b0, "R9 held value", int'(dout), 0);
    edges(ADDR_LAT - 1);
    check(rd_valid === 1'b0, "R5 early after reset", int'(rd_valid), 0);
    edges(1);
    check(rd_valid === 1'b1, "R5 valid after reset", int'(rd_valid), 1);

    // Vector table: R1 writes, reads against reference
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wr) begin
        addr = VEC[v].a; din = VEC[v].d; wr_sel = 1'b1;
        edges(1);
        wr_sel = 1'b0;
        ref_mem[VEC[v].a] = VEC[v].d;
        cur_a = VEC[v].a;
      end else begin
        addr = VEC[v].a;
        edges(ADDR_LAT - 1);
        if (VEC[v].a != cur_a)
          check(rd_valid === 1'b0, "R5 early read", int'(rd_valid), 0);
        edges(1);
        check_data("R1 readback", ref_mem[VEC[v].a]);
        cur_a = VEC[v].a;
      end
    end

    // R10 and R8: address change drops valid, old value held (00 holds 1)
    addr = 8'h5A;
    #1;
    check(rd_valid === 1'b0, "R10 drop on change", int'(rd_valid), 0);
    check(dout === 1'b1, "R8 hold old", int'(dout), 1);
    edges(2);
    check(rd_valid === 1'b0 && dout === 1'b1, "R8 hold pending", int'(dout), 1);
    edges(ADDR_LAT - 2);
    check_data("R5 new address", 1'b0);

    // R3 and R4: inhibited write attempt on 5A
    inhibit = 1'b1; wr_sel = 1'b1; din = 1'b1;
    #1;
    check(dout_en === 1'b0 && rd_valid === 1'b0, "R4 released", int'(dout_en), 0);
    edges(3);
    check(dout_en === 1'b0 && rd_valid === 1'b0, "R4 still released", int'(dout_en), 0);
    inhibit = 1'b0; wr_sel = 1'b0; din = 1'b0;
    #1;
    check(rd_valid === 1'b0, "R6 not instant", int'(rd_valid), 0);
    edges(INH_LAT);
    check_data("R3 write blocked / R6 fast", 1'b0);

    // R7: decode under inhibit, fast release
    inhibit = 1'b1; addr = 8'hFF;
    edges(ADDR_LAT);
    inhibit = 1'b0;
    #1;
    check(rd_valid === 1'b0, "R7 before release edge", int'(rd_valid), 0);
    edges(INH_LAT);
    check_data("R7 fast path", 1'b1);

    // R6/R5: release before decode finished still waits for decode
    inhibit = 1'b1; addr = 8'hA5;
    edges(2);
    inhibit = 1'b0;
    edges(INH_LAT);
    check(rd_valid === 1'b0, "R5 decode pending at release", int'(rd_valid), 0);
    edges(ADDR_LAT - 2 - INH_LAT);
    check_data("R5 decode done", 1'b0);

    // R2: repeated reads do not disturb
    for (int k = 0; k < 6; k++) begin
      edges(1);
      check_data("R2 repeat read", 1'b0);
    end

    // R1: write on a held address visible next cycle
    wr_sel = 1'b1; din = 1'b1;
    edges(1);
    wr_sel = 1'b0;
    #1;
    check_data("R1 write through", 1'b1);
    addr = 8'h5A;
    edges(ADDR_LAT);
    check_data("R2 neighbour intact", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule